// File: doc/BRIEF.md
# Indirect-Access Route Table with Entry Parity

This block holds one destination-ID routing table per output port. Each table maps a destination ID to an output-port number. Software never addresses table storage directly. It goes through a pair of registers: an index register that selects an entry, and a data register that reads or writes the port number at that index. Every port has its own register pair. A further broadcast pair writes the same entry into every table at once.

The index register has two control bits. The first makes the index step by one after each access to the data register, so software can fill or dump a whole table with back-to-back accesses. The second is a test control that stores every written entry with its parity bit flipped. A corrupted entry reads back normally. It only shows up when the packet path looks it up: the lookup then raises a one-cycle error pulse together with the failing destination ID. Each table has its own lookup port, with a fixed latency of one cycle.

Top module: `rt_route_cfg`

## Requirements
- R1: After reset, every index register (per-port and broadcast) reads 0x0000_0000, and reg_rvld_o, lkp_vld_o and par_err_o are low.
- R2: The index register layout is: auto-step at bit 31, parity-invert at bit 30, destination ID at bits 15:0 (upper byte 15:8). Bits 29:16 read as zero, and writes to them are ignored.
- R3: With auto-step set, each write of the data register (reg_addr_i=1) stores the low PORT_W bits of the write data at the current index. It then advances the index by one.
- R4: A read of the data register returns the stored port number, zero-extended, on reg_rdata_o with reg_rvld_o one cycle after the request. With auto-step set, the read also advances the index.
- R5: Index stepping wraps from 0xFFFF to 0x0000, and a carry out of the low byte increments the upper byte (0x00FF steps to 0x0100).
- R6: With auto-step clear, data-register accesses and index-register reads leave the index unchanged.
- R7: A lookup on table p returns the entry at the low IDX_W bits of the lookup ID, with lkp_vld_o high exactly one cycle later. Lookups on several tables may run in the same cycle.
- R8: An entry written while parity-invert is set gives par_err_o high for the one cycle of its lookup result, and err_id_o then carries the full lookup ID. An entry written normally gives no error.
- R9: Parity-invert does not change what a data-register read returns.
- R10: Broadcast select (reg_sel_i = NUM_PORTS) writes all tables at the broadcast index. A broadcast data read returns table 0. The broadcast index and the per-port indices are independent.
- R11: If a register write and a lookup hit the same entry in the same cycle, the lookup returns the entry as it was before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe (has priority over read) |
| reg_rd_i | input | 1 | Register read strobe |
| reg_sel_i | input | $clog2(NUM_PORTS+1) | Register copy: port number, or NUM_PORTS for broadcast |
| reg_addr_i | input | 1 | 0 = index register, 1 = data register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data |
| reg_rvld_o | output | 1 | Read data valid, one cycle after the read |
| lkp_vld_i | input | NUM_PORTS | Lookup request per table |
| lkp_id_i | input | NUM_PORTS*16 | Lookup destination ID per table |
| lkp_vld_o | output | NUM_PORTS | Lookup result valid per table |
| lkp_port_o | output | NUM_PORTS*PORT_W | Looked-up port number per table |
| par_err_o | output | NUM_PORTS | Parity error pulse per table |
| err_id_o | output | NUM_PORTS*16 | Lookup ID of the result; meaningful with par_err_o |

## Verification
The hardest condition to reach is a parity error. It needs an entry stored with flipped parity, the invert control turned back off or left alone, and then a lookup of that exact entry on the packet side. None of that is visible through register reads. The stimulus sets the invert bit on one port's copy and writes a single entry. It first confirms that a register read still returns the clean value. It then looks the entry up with extra upper ID bits, so the error ID can be told apart from the table index. Finally it rewrites the entry with the invert bit clear and shows that the error goes away. A second corner case is a write and a lookup of the same entry in one cycle, which is driven from a single negative edge.

// File: rtl/rt_route_pkg.sv
package rt_route_pkg;
  localparam int unsigned DID_W    = 16;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned AUTO_BIT = 31;
  localparam int unsigned INV_BIT  = 30;

  typedef enum logic {
    REG_IDX  = 1'b0,
    REG_PORT = 1'b1
  } reg_addr_e;

  typedef struct packed {
    logic             auto_inc;
    logic             par_inv;
    logic [DID_W-1:0] did;
  } idx_cfg_t;
endpackage

// File: rtl/rt_idx_reg.sv
module rt_idx_reg
  import rt_route_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic             ld_auto_i,
  input  logic             ld_inv_i,
  input  logic [DID_W-1:0] ld_did_i,
  input  logic             step_i,
  output idx_cfg_t         cfg_o
);
  localparam int unsigned HALF = DID_W / 2;

  idx_cfg_t        cfg_q;
  logic [HALF-1:0] lo_nxt, hi_nxt;
  logic            lo_carry;

  // byte-wise step: carry out of low half feeds upper half
  always_comb begin
    {lo_carry, lo_nxt} = {1'b0, cfg_q.did[HALF-1:0]} + {{HALF{1'b0}}, 1'b1};
    hi_nxt = cfg_q.did[DID_W-1:HALF] + {{(HALF-1){1'b0}}, lo_carry};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (ld_i) begin
      cfg_q.auto_inc <= ld_auto_i;
      cfg_q.par_inv  <= ld_inv_i;
      cfg_q.did      <= ld_did_i;
    end else if (step_i && cfg_q.auto_inc) begin
      cfg_q.did <= {hi_nxt, lo_nxt};
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/rt_table.sv
module rt_table
  import rt_route_pkg::*;
#(
  parameter int unsigned PORT_W = 4,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [PORT_W-1:0] wr_port_i,
  input  logic              wr_inv_i,
  input  logic [IDX_W-1:0]  cfg_addr_i,
  output logic [PORT_W-1:0] cfg_port_o,
  input  logic              lkp_vld_i,
  input  logic [DID_W-1:0]  lkp_id_i,
  output logic              lkp_vld_o,
  output logic [PORT_W-1:0] lkp_port_o,
  output logic              par_err_o,
  output logic [DID_W-1:0]  err_id_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam int unsigned ENT_W = PORT_W + 1;

  // entry layout: {parity, port}
  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] ent_q;
  logic [DID_W-1:0] id_q;
  logic             vld_q;
  logic             wr_par;

  assign wr_par = (^wr_port_i) ^ wr_inv_i;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= {wr_par, wr_port_i};
  end

  assign cfg_port_o = mem[cfg_addr_i][PORT_W-1:0];

  // lookup read samples pre-write contents on a same-cycle collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      ent_q <= '0;
      id_q  <= '0;
    end else begin
      vld_q <= lkp_vld_i;
      if (lkp_vld_i) begin
        ent_q <= mem[lkp_id_i[IDX_W-1:0]];
        id_q  <= lkp_id_i;
      end
    end
  end

  assign lkp_vld_o  = vld_q;
  assign lkp_port_o = ent_q[PORT_W-1:0];
  assign par_err_o  = vld_q && ((^ent_q[PORT_W-1:0]) != ent_q[PORT_W]);
  assign err_id_o   = id_q;
endmodule

// File: rtl/rt_route_cfg.sv
module rt_route_cfg
  import rt_route_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PORT_W    = 4,
  parameter int unsigned IDX_W     = 6,
  localparam int unsigned NUM_CP   = NUM_PORTS + 1,
  localparam int unsigned SEL_W    = $clog2(NUM_CP)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          reg_wr_i,
  input  logic                          reg_rd_i,
  input  logic [SEL_W-1:0]              reg_sel_i,
  input  logic                          reg_addr_i,
  input  logic [REG_W-1:0]              reg_wdata_i,
  output logic [REG_W-1:0]              reg_rdata_o,
  output logic                          reg_rvld_o,
  input  logic [NUM_PORTS-1:0]          lkp_vld_i,
  input  logic [NUM_PORTS*DID_W-1:0]    lkp_id_i,
  output logic [NUM_PORTS-1:0]          lkp_vld_o,
  output logic [NUM_PORTS*PORT_W-1:0]   lkp_port_o,
  output logic [NUM_PORTS-1:0]          par_err_o,
  output logic [NUM_PORTS*DID_W-1:0]    err_id_o
);
  localparam int unsigned BCAST = NUM_PORTS;
  localparam int unsigned RSV_W = INV_BIT - DID_W;

  idx_cfg_t           cp_cfg  [NUM_CP];
  logic [REG_W-1:0]   cp_rval [NUM_CP];
  logic [NUM_CP-1:0]  cp_hit, cp_ld, cp_step;
  logic [PORT_W-1:0]  tbl_cfg_port [NUM_PORTS];
  logic               acc_port, acc_idx, rd_eff;
  logic [REG_W-1:0]   rd_next;
  logic               unused_rsv;

  assign unused_rsv = ^reg_wdata_i[INV_BIT-1:DID_W];
  assign acc_port   = (reg_addr_i == REG_PORT);
  assign acc_idx    = (reg_addr_i == REG_IDX);
  assign rd_eff     = reg_rd_i && !reg_wr_i;

  for (genvar c = 0; c < NUM_CP; c++) begin : g_cp
    assign cp_hit[c]  = (reg_sel_i == SEL_W'(c));
    assign cp_ld[c]   = cp_hit[c] && reg_wr_i && acc_idx;
    assign cp_step[c] = cp_hit[c] && (reg_wr_i || reg_rd_i) && acc_port;

    rt_idx_reg u_idx (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ld_i      (cp_ld[c]),
      .ld_auto_i (reg_wdata_i[AUTO_BIT]),
      .ld_inv_i  (reg_wdata_i[INV_BIT]),
      .ld_did_i  (reg_wdata_i[DID_W-1:0]),
      .step_i    (cp_step[c]),
      .cfg_o     (cp_cfg[c])
    );

    logic [PORT_W-1:0] data_val;
    if (c == BCAST) begin : g_bc
      assign data_val = tbl_cfg_port[0];
    end else begin : g_pt
      assign data_val = tbl_cfg_port[c];
    end

    assign cp_rval[c] = acc_idx
      ? {cp_cfg[c].auto_inc, cp_cfg[c].par_inv, {RSV_W{1'b0}}, cp_cfg[c].did}
      : {{(REG_W-PORT_W){1'b0}}, data_val};
  end

  for (genvar t = 0; t < NUM_PORTS; t++) begin : g_tbl
    logic             bc_sel;
    logic [IDX_W-1:0] t_addr;
    logic             t_inv;

    assign bc_sel = cp_hit[BCAST];
    assign t_addr = bc_sel ? cp_cfg[BCAST].did[IDX_W-1:0] : cp_cfg[t].did[IDX_W-1:0];
    assign t_inv  = bc_sel ? cp_cfg[BCAST].par_inv : cp_cfg[t].par_inv;

    rt_table #(
      .PORT_W (PORT_W),
      .IDX_W  (IDX_W)
    ) u_tbl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (reg_wr_i && acc_port && (cp_hit[t] || bc_sel)),
      .wr_addr_i  (t_addr),
      .wr_port_i  (reg_wdata_i[PORT_W-1:0]),
      .wr_inv_i   (t_inv),
      .cfg_addr_i (t_addr),
      .cfg_port_o (tbl_cfg_port[t]),
      .lkp_vld_i  (lkp_vld_i[t]),
      .lkp_id_i   (lkp_id_i[t*DID_W +: DID_W]),
      .lkp_vld_o  (lkp_vld_o[t]),
      .lkp_port_o (lkp_port_o[t*PORT_W +: PORT_W]),
      .par_err_o  (par_err_o[t]),
      .err_id_o   (err_id_o[t*DID_W +: DID_W])
    );
  end

  always_comb begin
    rd_next = '0;
    for (int c = 0; c < NUM_CP; c++) begin
      if (cp_hit[c]) rd_next = cp_rval[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rvld_o  <= 1'b0;
      reg_rdata_o <= '0;
    end else begin
      reg_rvld_o <= rd_eff;
      if (rd_eff) reg_rdata_o <= rd_next;
    end
  end
endmodule

// File: rtl/rt_route_cfg_chk.sv
module rt_route_cfg_chk #(
  parameter int unsigned SEL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_wr_i,
  input logic             reg_rd_i,
  input logic [SEL_W-1:0] reg_sel_i,
  input logic             reg_addr_i,
  input logic             reg_rvld_o,
  input logic [31:0]      reg_rdata_o,
  input logic             lkp_vld0_i,
  input logic             lkp_vld0_o,
  input logic             par_err0_o,
  input logic [15:0]      did0,
  input logic             auto0
);
  logic p0_port_acc, p0_idx_wr;
  assign p0_port_acc = (reg_wr_i || reg_rd_i) && (reg_sel_i == '0) && reg_addr_i;
  assign p0_idx_wr   = reg_wr_i && (reg_sel_i == '0) && !reg_addr_i;

  AST_RVLD_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && !reg_wr_i) |=> reg_rvld_o); // R4
  AST_RVLD_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rvld_o |-> $past(reg_rd_i && !reg_wr_i)); // R4
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rvld_o |-> (reg_rdata_o[29:16] == 14'd0)); // R2
  AST_AUTO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p0_port_acc && auto0) |=> (did0 == $past(did0) + 16'd1)); // R3
  AST_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p0_port_acc && !auto0) |=> $stable(did0)); // R6
  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!p0_port_acc && !p0_idx_wr) |=> $stable(did0)); // R6
  AST_LKP_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_vld0_i |=> lkp_vld0_o); // R7
  AST_ERR_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err0_o |-> lkp_vld0_o); // R8
endmodule

bind rt_route_cfg rt_route_cfg_chk #(.SEL_W(SEL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_sel_i   (reg_sel_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rvld_o  (reg_rvld_o),
  .reg_rdata_o (reg_rdata_o),
  .lkp_vld0_i  (lkp_vld_i[0]),
  .lkp_vld0_o  (lkp_vld_o[0]),
  .par_err0_o  (par_err_o[0]),
  .did0        (cp_cfg[0].did),
  .auto0       (cp_cfg[0].auto_inc)
);

// File: tb/tb_rt_route_cfg.sv
module tb_rt_route_cfg;
  localparam int NP = 4;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
  logic [2:0]    reg_sel = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          reg_rvld;
  logic [NP-1:0] lkp_vld = '0;
  logic [NP*16-1:0] lkp_id = '0;
  logic [NP-1:0] lkp_vld_o, par_err;
  logic [NP*PW-1:0] lkp_port;
  logic [NP*16-1:0] err_id;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rt_route_cfg dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_sel_i(reg_sel),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .reg_rvld_o(reg_rvld),
    .lkp_vld_i(lkp_vld), .lkp_id_i(lkp_id),
    .lkp_vld_o(lkp_vld_o), .lkp_port_o(lkp_port),
    .par_err_o(par_err), .err_id_o(err_id)
  );

  typedef struct packed {
    logic        rd;
    logic [2:0]  sel;
    logic        addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'd0, 1'b0, 32'h0,         32'h0,         4'd1},  // R1
    '{1'b1, 3'd4, 1'b0, 32'h0,         32'h0,         4'd1},  // R1
    '{1'b0, 3'd0, 1'b0, 32'h3FFF_0005, 32'h0,         4'd2},
    '{1'b1, 3'd0, 1'b0, 32'h0,         32'h0000_0005, 4'd2},  // R2
    '{1'b0, 3'd0, 1'b1, 32'h7,         32'h0,         4'd6},
    '{1'b1, 3'd0, 1'b0, 32'h0,         32'h0000_0005, 4'd6},  // R6
    '{1'b1, 3'd0, 1'b1, 32'h0,         32'h7,         4'd6},
    '{1'b1, 3'd0, 1'b0, 32'h0,         32'h0000_0005, 4'd6},  // R6
    '{1'b0, 3'd0, 1'b0, 32'h8000_0010, 32'h0,         4'd3},
    '{1'b0, 3'd0, 1'b1, 32'h3,         32'h0,         4'd3},
    '{1'b0, 3'd0, 1'b1, 32'hFFFF_FFF9, 32'h0,         4'd3},
    '{1'b1, 3'd0, 1'b0, 32'h0,         32'h8000_0012, 4'd3},  // R3
    '{1'b0, 3'd0, 1'b0, 32'h8000_0010, 32'h0,         4'd4},
    '{1'b1, 3'd0, 1'b1, 32'h0,         32'h3,         4'd4},  // R4
    '{1'b1, 3'd0, 1'b1, 32'h0,         32'h9,         4'd4},
    '{1'b1, 3'd0, 1'b0, 32'h0,         32'h8000_0012, 4'd4},
    '{1'b0, 3'd0, 1'b0, 32'h8000_FFFF, 32'h0,         4'd5},
    '{1'b0, 3'd0, 1'b1, 32'h2,         32'h0,         4'd5},
    '{1'b1, 3'd0, 1'b0, 32'h0,         32'h8000_0000, 4'd5},  // R5
    '{1'b0, 3'd0, 1'b0, 32'h8000_00FF, 32'h0,         4'd5},
    '{1'b0, 3'd0, 1'b1, 32'h1,         32'h0,         4'd5},
    '{1'b1, 3'd0, 1'b0, 32'h0,         32'h8000_0100, 4'd5},  // R5
    '{1'b0, 3'd4, 1'b0, 32'h8000_0020, 32'h0,         4'd10},
    '{1'b0, 3'd4, 1'b1, 32'hA,         32'h0,         4'd10},
    '{1'b0, 3'd4, 1'b1, 32'hB,         32'h0,         4'd10},
    '{1'b1, 3'd4, 1'b0, 32'h0,         32'h8000_0022, 4'd10}, // R10
    '{1'b0, 3'd2, 1'b0, 32'h0000_0021, 32'h0,         4'd10},
    '{1'b1, 3'd2, 1'b1, 32'h0,         32'hB,         4'd10},
    '{1'b0, 3'd3, 1'b0, 32'h0000_0020, 32'h0,         4'd10},
    '{1'b1, 3'd3, 1'b1, 32'h0,         32'hA,         4'd10},
    '{1'b1, 3'd0, 1'b0, 32'h0,         32'h8000_0100, 4'd10},
    '{1'b0, 3'd1, 1'b0, 32'h4000_0030, 32'h0,         4'd9},
    '{1'b0, 3'd1, 1'b1, 32'h6,         32'h0,         4'd9},
    '{1'b1, 3'd1, 1'b1, 32'h0,         32'h6,         4'd9},  // R9
    '{1'b1, 3'd1, 1'b0, 32'h0,         32'h4000_0030, 4'd9}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic reg_op(input logic rd, input logic [2:0] sel, input logic addr,
                        input logic [31:0] data);
    @(negedge clk);
    reg_wr = ~rd; reg_rd = rd; reg_sel = sel; reg_addr = addr; reg_wdata = data;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  task automatic look(input int t, input logic [15:0] id, input logic [3:0] exp_port,
                      input logic exp_err, input string tag);
    @(negedge clk);
    lkp_vld[t] = 1'b1; lkp_id[t*16 +: 16] = id;
    @(posedge clk);
    @(negedge clk);
    lkp_vld = '0;
    chk({tag, " vld"}, 32'(lkp_vld_o[t]), 32'd1);
    chk({tag, " port"}, 32'(lkp_port[t*PW +: PW]), 32'(exp_port));
    chk({tag, " err"}, 32'(par_err[t]), 32'(exp_err));
    if (exp_err) chk({tag, " err_id"}, 32'(err_id[t*16 +: 16]), 32'(id));
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 rvld", 32'(reg_rvld), 32'd0);
    chk("R1 lkp_vld", 32'(lkp_vld_o), 32'd0);
    chk("R1 par_err", 32'(par_err), 32'd0);

    for (int i = 0; i < NV; i++) begin
      reg_op(VEC[i].rd, VEC[i].sel, VEC[i].addr, VEC[i].data);
      if (VEC[i].rd) begin
        checks++;
        if (!reg_rvld || reg_rdata !== VEC[i].exp) begin
          errors++;
          $display("FAIL R%0d vec %0d act=%h/%b exp=%h/1", VEC[i].req, i,
                   reg_rdata, reg_rvld, VEC[i].exp);
        end
      end
    end

    // R7 lookups
    look(2, 16'h0021, 4'hB, 1'b0, "R7 t2");
    look(0, 16'h0010, 4'h3, 1'b0, "R7 t0");
    look(0, 16'h013F, 4'h1, 1'b0, "R7 t0 upper bits");
    // R7 two tables in one cycle
    @(negedge clk);
    lkp_vld = 4'b1100; lkp_id[2*16 +: 16] = 16'h0021; lkp_id[3*16 +: 16] = 16'h0020;
    @(posedge clk);
    @(negedge clk);
    lkp_vld = '0;
    chk("R7 dual vld", 32'(lkp_vld_o), 32'b1100);
    chk("R7 dual t2", 32'(lkp_port[2*PW +: PW]), 32'hB);
    chk("R7 dual t3", 32'(lkp_port[3*PW +: PW]), 32'hA);

    // R8 corrupted entry on table 1
    look(1, 16'h1230, 4'h6, 1'b1, "R8 inverted");
    @(negedge clk);
    chk("R8 pulse ends", 32'(par_err[1]), 32'd0);
    reg_op(1'b0, 3'd1, 1'b0, 32'h0000_0030);
    reg_op(1'b0, 3'd1, 1'b1, 32'h6);
    look(1, 16'h0030, 4'h6, 1'b0, "R8 rewritten");

    // R11 write and lookup of one entry in the same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 3'd1; reg_addr = 1'b1; reg_wdata = 32'hC;
    lkp_vld[1] = 1'b1; lkp_id[1*16 +: 16] = 16'h0030;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; lkp_vld = '0;
    chk("R11 old entry", 32'(lkp_port[1*PW +: PW]), 32'h6);
    look(1, 16'h0030, 4'hC, 1'b0, "R11 new entry");

    finish_run();
  end
endmodule